// File: doc/BRIEF.md
# Sixteen-Pin GPIO Port with Atomic Data Update

This block is one general-purpose I/O port of sixteen pins. Software reaches it over a simple synchronous register bus: one address, one write strobe, write data and a combinational read word. Each pin has its own settings:

- whether it drives out;
- whether its input path is enabled;
- which function owns it: the GPIO registers or one of up to four peripheral signal pairs;
- how it raises an interrupt: level, rising edge, or both edges.

The output data can be changed atomically. Dedicated addresses set, clear or toggle only the bits written as one. A further address carries a set half and a clear half in one word. Because of this, concurrent software agents never need a read-modify-write of the data register.

On the pin side the block drives an output vector and an output-enable vector, and receives the pad input vector. When a pin both drives and has its input enabled, the value it drives is fed back as its input, in place of the pad value. Enabled inputs pass through one register stage, and interrupt detection works on that stage. A single interrupt line is the OR of all masked pin status bits. Edge status bits hold their value until software clears them.

Top module: `pinPort`

## Requirements
- R1: After reset every pin is a GPIO input with input disabled: the output enable, output data, input value, interrupt masks and function selects all read zero, and `irq` is low.
- R2: For a pin whose function select is GPIO, `padOe` equals its direction bit (address 0, 1 = output), and `padOut` equals its data bit (address 1).
- R3: Writes to address 2 set, to address 3 clear and to address 4 toggle exactly the data bits written as one. All other data bits are left unchanged.
- R4: A write to address 5 sets the data bits marked in write bits 15:0 and clears the data bits marked in bits 31:16. A pin marked in both halves ends up cleared.
- R5: The input value (read at address 11) is registered once. For each pin it is zero when the input enable bit (address 6) is off. Otherwise it is the pin's own output value when `padOe` is high, and the pad input when `padOe` is low.
- R6: Each pin has a 3-bit function select held in a 4-bit slot: pins 0-7 use address 12 and pins 8-15 use address 13, with pin n at slot bits [4(n mod 8)+2 : 4(n mod 8)]. Values 1 to 4 hand the pin's output and output enable to peripheral A to D. Peripheral k, pin n sits at bit 16k+n of `periphOut`/`periphOe`. Values 0 and 5 to 7 select GPIO.
- R7: With the edge bit (address 8) at zero, the pin's status bit (address 10) follows its input value.
- R8: With the edge bit set and the both-edges bit (address 9) clear, a rising input sets a sticky status bit. A falling input does not set it. Writing a one to address 10 clears the bit.
- R9: With the edge bit and the both-edges bit set, both a rising and a falling input set the sticky status bit.
- R10: `irq` is high exactly when some pin has both its status bit and its mask bit (address 7) set. The mask does not change the status read.
- R11: A pin that is an output with input enabled raises its interrupt when software writes its data, through the internal loopback.
- R12: Writing ones to address 10 has no effect on level-mode status bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| busAddr | input | 4 | Register word address |
| busWr | input | 1 | Write strobe |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for busAddr (combinational) |
| padIn | input | 16 | Value seen at each pad |
| padOut | output | 16 | Value driven towards each pad |
| padOe | output | 16 | Output enable per pad |
| periphOut | input | 64 | Peripheral output values, 16 bits per peripheral A-D |
| periphOe | input | 64 | Peripheral output enables, 16 bits per peripheral A-D |
| irq | output | 1 | Port interrupt request |

## Verification
The bench writes a set-and-clear word that marks the same pins in both halves. A design that gave priority to the set half would leave those pins high. It drives loopback pins with the pad held at the opposite level, so reading the pad instead of the driven value shows up as flipped input bits.

Function-select values 5 to 7 and peripheral signals on unselected pins are driven to expose a decoder that forwards the wrong peripheral or treats reserved codes as peripherals. The bench also separates the three sensitivities by pulsing pins in both directions. A rising-only pin that latched a fall would show status, and a level pin that accepted a status clear would lose it. It sets status behind a cleared mask to confirm that `irq` stays low until the mask opens.

// File: rtl/pinPortPkg.sv
package pinPortPkg;
  localparam int ADDR_W = 4;
  localparam int FSEL_W = 3;
  localparam int FSEL_SLOT = 4;
  localparam int MAX_FSEL_WORDS = 4;

  localparam logic [ADDR_W-1:0] A_DIR   = 4'd0;
  localparam logic [ADDR_W-1:0] A_DATA  = 4'd1;
  localparam logic [ADDR_W-1:0] A_SET   = 4'd2;
  localparam logic [ADDR_W-1:0] A_CLR   = 4'd3;
  localparam logic [ADDR_W-1:0] A_TGL   = 4'd4;
  localparam logic [ADDR_W-1:0] A_MOD   = 4'd5;
  localparam logic [ADDR_W-1:0] A_INEN  = 4'd6;
  localparam logic [ADDR_W-1:0] A_MASK  = 4'd7;
  localparam logic [ADDR_W-1:0] A_EDGE  = 4'd8;
  localparam logic [ADDR_W-1:0] A_BOTH  = 4'd9;
  localparam logic [ADDR_W-1:0] A_STAT  = 4'd10;
  localparam logic [ADDR_W-1:0] A_INVAL = 4'd11;
  localparam logic [ADDR_W-1:0] A_FSEL0 = 4'd12;

  typedef struct packed {
    logic wrDir;
    logic wrData;
    logic wrSet;
    logic wrClr;
    logic wrTgl;
    logic wrMod;
    logic wrInEn;
    logic wrMask;
    logic wrEdge;
    logic wrBoth;
    logic wrStatClr;
    logic [MAX_FSEL_WORDS-1:0] wrFsel;
  } ctrlStrobesT;
endpackage

// File: rtl/pinPortCtrl.sv
module pinPortCtrl
  import pinPortPkg::*;
#(
  parameter int NUM_PINS = 16,
  parameter int DATA_W = 32
) (
  input  logic [ADDR_W-1:0]          busAddr,
  input  logic                       busWr,
  input  logic [NUM_PINS-1:0]        dirQ,
  input  logic [NUM_PINS-1:0]        dataQ,
  input  logic [NUM_PINS-1:0]        inEnQ,
  input  logic [NUM_PINS-1:0]        maskQ,
  input  logic [NUM_PINS-1:0]        edgeQ,
  input  logic [NUM_PINS-1:0]        bothQ,
  input  logic [NUM_PINS-1:0]        statQ,
  input  logic [NUM_PINS-1:0]        inValQ,
  input  logic [NUM_PINS*FSEL_W-1:0] fselQ,
  output ctrlStrobesT                strobes,
  output logic [DATA_W-1:0]          busRdata
);
  localparam int PER_WORD = DATA_W / FSEL_SLOT;

  always_comb begin
    strobes = '0;
    if (busWr) begin
      strobes.wrDir     = (busAddr == A_DIR);
      strobes.wrData    = (busAddr == A_DATA);
      strobes.wrSet     = (busAddr == A_SET);
      strobes.wrClr     = (busAddr == A_CLR);
      strobes.wrTgl     = (busAddr == A_TGL);
      strobes.wrMod     = (busAddr == A_MOD);
      strobes.wrInEn    = (busAddr == A_INEN);
      strobes.wrMask    = (busAddr == A_MASK);
      strobes.wrEdge    = (busAddr == A_EDGE);
      strobes.wrBoth    = (busAddr == A_BOTH);
      strobes.wrStatClr = (busAddr == A_STAT);
      for (int w = 0; w < MAX_FSEL_WORDS; w++)
        strobes.wrFsel[w] = (busAddr == A_FSEL0 + ADDR_W'(w));
    end
  end

  always_comb begin
    busRdata = '0;
    case (busAddr)
      A_DIR:                      busRdata[NUM_PINS-1:0] = dirQ;
      A_DATA, A_SET, A_CLR,
      A_TGL, A_MOD:               busRdata[NUM_PINS-1:0] = dataQ;
      A_INEN:                     busRdata[NUM_PINS-1:0] = inEnQ;
      A_MASK:                     busRdata[NUM_PINS-1:0] = maskQ;
      A_EDGE:                     busRdata[NUM_PINS-1:0] = edgeQ;
      A_BOTH:                     busRdata[NUM_PINS-1:0] = bothQ;
      A_STAT:                     busRdata[NUM_PINS-1:0] = statQ;
      A_INVAL:                    busRdata[NUM_PINS-1:0] = inValQ;
      default: begin
        for (int i = 0; i < NUM_PINS; i++)
          if (busAddr == A_FSEL0 + ADDR_W'(i / PER_WORD))
            busRdata[FSEL_SLOT*(i % PER_WORD) +: FSEL_W] = fselQ[i*FSEL_W +: FSEL_W];
      end
    endcase
  end
endmodule

// File: rtl/pinPortDatapath.sv
module pinPortDatapath
  import pinPortPkg::*;
#(
  parameter int NUM_PINS = 16,
  parameter int NUM_PERIPH = 4,
  parameter int DATA_W = 32
) (
  input  logic                           clk,
  input  logic                           rst,
  input  ctrlStrobesT                    strobes,
  input  logic [DATA_W-1:0]              wdata,
  input  logic [NUM_PINS-1:0]            padIn,
  input  logic [NUM_PERIPH*NUM_PINS-1:0] periphOut,
  input  logic [NUM_PERIPH*NUM_PINS-1:0] periphOe,
  output logic [NUM_PINS-1:0]            padOut,
  output logic [NUM_PINS-1:0]            padOe,
  output logic [NUM_PINS-1:0]            dirQ,
  output logic [NUM_PINS-1:0]            dataQ,
  output logic [NUM_PINS-1:0]            inEnQ,
  output logic [NUM_PINS-1:0]            maskQ,
  output logic [NUM_PINS-1:0]            edgeQ,
  output logic [NUM_PINS-1:0]            bothQ,
  output logic [NUM_PINS-1:0]            statQ,
  output logic [NUM_PINS-1:0]            inValQ,
  output logic [NUM_PINS*FSEL_W-1:0]     fselQ,
  output logic                           irq
);
  localparam int PER_WORD = DATA_W / FSEL_SLOT;

  logic [NUM_PINS-1:0] wLo, wHi, dataNext;
  logic [NUM_PINS-1:0] rawIn, prevQ, stickyQ, edgeEvent;
  logic [FSEL_W-1:0]   fselArr [NUM_PINS];

  assign wLo = wdata[NUM_PINS-1:0];
  assign wHi = wdata[2*NUM_PINS-1:NUM_PINS];

  // plain configuration registers
  always_ff @(posedge clk) begin
    if (rst) begin
      dirQ  <= '0;
      inEnQ <= '0;
      maskQ <= '0;
      edgeQ <= '0;
      bothQ <= '0;
    end else begin
      if (strobes.wrDir)  dirQ  <= wLo;
      if (strobes.wrInEn) inEnQ <= wLo;
      if (strobes.wrMask) maskQ <= wLo;
      if (strobes.wrEdge) edgeQ <= wLo;
      if (strobes.wrBoth) bothQ <= wLo;
    end
  end

  // output data with atomic modify; clear half applied last so it wins
  always_comb begin
    dataNext = dataQ;
    if (strobes.wrData) dataNext = wLo;
    if (strobes.wrSet)  dataNext = dataQ | wLo;
    if (strobes.wrClr)  dataNext = dataQ & ~wLo;
    if (strobes.wrTgl)  dataNext = dataQ ^ wLo;
    if (strobes.wrMod)  dataNext = (dataQ | wLo) & ~wHi;
  end

  always_ff @(posedge clk) begin
    if (rst) dataQ <= '0;
    else     dataQ <= dataNext;
  end

  // function select per pin
  for (genvar i = 0; i < NUM_PINS; i++) begin : g_fsel
    always_ff @(posedge clk) begin
      if (rst)
        fselArr[i] <= '0;
      else if (strobes.wrFsel[i / PER_WORD])
        fselArr[i] <= wdata[FSEL_SLOT*(i % PER_WORD) +: FSEL_W];
    end
    assign fselQ[i*FSEL_W +: FSEL_W] = fselArr[i];
  end

  // pin output multiplexer
  always_comb begin
    padOut = dataQ;
    padOe  = dirQ;
    for (int i = 0; i < NUM_PINS; i++) begin
      for (int k = 0; k < NUM_PERIPH; k++) begin
        if (fselArr[i] == FSEL_W'(k + 1)) begin
          padOut[i] = periphOut[k*NUM_PINS + i];
          padOe[i]  = periphOe[k*NUM_PINS + i];
        end
      end
    end
  end

  // input path with loopback of the driven value
  assign rawIn = inEnQ & ((padOe & padOut) | (~padOe & padIn));

  always_ff @(posedge clk) begin
    if (rst) begin
      inValQ <= '0;
      prevQ  <= '0;
    end else begin
      inValQ <= rawIn;
      prevQ  <= inValQ;
    end
  end

  assign edgeEvent = edgeQ & ((inValQ & ~prevQ) | (bothQ & ~inValQ & prevQ));

  // sticky edge status: a new event beats a same-cycle clear
  always_ff @(posedge clk) begin
    if (rst)
      stickyQ <= '0;
    else
      stickyQ <= ((stickyQ & ~(strobes.wrStatClr ? wLo : '0)) | edgeEvent) & edgeQ;
  end

  assign statQ = (edgeQ & stickyQ) | (~edgeQ & inValQ);
  assign irq   = |(statQ & maskQ);
endmodule

// File: rtl/pinPort.sv
module pinPort
  import pinPortPkg::*;
#(
  parameter int NUM_PINS = 16,
  parameter int NUM_PERIPH = 4,
  parameter int DATA_W = 32
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic [ADDR_W-1:0]              busAddr,
  input  logic                           busWr,
  input  logic [DATA_W-1:0]              busWdata,
  output logic [DATA_W-1:0]              busRdata,
  input  logic [NUM_PINS-1:0]            padIn,
  output logic [NUM_PINS-1:0]            padOut,
  output logic [NUM_PINS-1:0]            padOe,
  input  logic [NUM_PERIPH*NUM_PINS-1:0] periphOut,
  input  logic [NUM_PERIPH*NUM_PINS-1:0] periphOe,
  output logic                           irq
);
  ctrlStrobesT strobes;
  logic [NUM_PINS-1:0] dirQ, dataQ, inEnQ, maskQ, edgeQ, bothQ, statQ, inValQ;
  logic [NUM_PINS*FSEL_W-1:0] fselQ;

  pinPortCtrl #(.NUM_PINS(NUM_PINS), .DATA_W(DATA_W)) u_ctrl (
    .busAddr(busAddr), .busWr(busWr),
    .dirQ(dirQ), .dataQ(dataQ), .inEnQ(inEnQ), .maskQ(maskQ),
    .edgeQ(edgeQ), .bothQ(bothQ), .statQ(statQ), .inValQ(inValQ),
    .fselQ(fselQ), .strobes(strobes), .busRdata(busRdata)
  );

  pinPortDatapath #(.NUM_PINS(NUM_PINS), .NUM_PERIPH(NUM_PERIPH), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rst(rst), .strobes(strobes), .wdata(busWdata),
    .padIn(padIn), .periphOut(periphOut), .periphOe(periphOe),
    .padOut(padOut), .padOe(padOe),
    .dirQ(dirQ), .dataQ(dataQ), .inEnQ(inEnQ), .maskQ(maskQ),
    .edgeQ(edgeQ), .bothQ(bothQ), .statQ(statQ), .inValQ(inValQ),
    .fselQ(fselQ), .irq(irq)
  );
endmodule

// File: rtl/pinPortChecker.sv
module pinPortChecker
  import pinPortPkg::*;
#(
  parameter int NUM_PINS = 16,
  parameter int DATA_W = 32
) (
  input logic                clk,
  input logic                rst,
  input logic [DATA_W-1:0]   busWdata,
  input ctrlStrobesT         strobes,
  input logic [NUM_PINS-1:0] dataQ,
  input logic [NUM_PINS-1:0] inEnQ,
  input logic [NUM_PINS-1:0] inValQ,
  input logic [NUM_PINS-1:0] maskQ,
  input logic [NUM_PINS-1:0] padOe,
  input logic                irq
);
  assert_reset_R1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (padOe == '0 && dataQ == '0 && !irq));

  assert_set_R3: assert property (@(posedge clk) disable iff (rst)
    strobes.wrSet |=> ((dataQ & $past(busWdata[NUM_PINS-1:0])) == $past(busWdata[NUM_PINS-1:0])));

  assert_clr_R3: assert property (@(posedge clk) disable iff (rst)
    strobes.wrClr |=> ((dataQ & $past(busWdata[NUM_PINS-1:0])) == '0));

  assert_untouched_R3: assert property (@(posedge clk) disable iff (rst)
    (strobes.wrSet || strobes.wrClr || strobes.wrTgl) |=>
      ((dataQ & ~$past(busWdata[NUM_PINS-1:0])) == ($past(dataQ) & ~$past(busWdata[NUM_PINS-1:0]))));

  assert_clear_wins_R4: assert property (@(posedge clk) disable iff (rst)
    strobes.wrMod |=> ((dataQ & $past(busWdata[2*NUM_PINS-1:NUM_PINS])) == '0));

  assert_input_gated_R5: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((inValQ & ~$past(inEnQ)) == '0));

  assert_irq_needs_mask_R10: assert property (@(posedge clk) disable iff (rst)
    irq |-> (maskQ != '0));
endmodule

bind pinPort pinPortChecker #(.NUM_PINS(NUM_PINS), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .busWdata(busWdata), .strobes(strobes),
  .dataQ(dataQ), .inEnQ(inEnQ), .inValQ(inValQ), .maskQ(maskQ),
  .padOe(padOe), .irq(irq)
);

// File: tb/pinPort_test.sv
module pinPort_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  busAddr = '0;
  logic        busWr = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [15:0] padIn = '0;
  logic [15:0] padOut, padOe;
  logic [63:0] periphOut = '0;
  logic [63:0] periphOe = '0;
  logic        irq;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pinPort uut (
    .clk(clk), .rst(rst), .busAddr(busAddr), .busWr(busWr),
    .busWdata(busWdata), .busRdata(busRdata), .padIn(padIn),
    .padOut(padOut), .padOe(padOe), .periphOut(periphOut),
    .periphOe(periphOe), .irq(irq)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWr = 1'b1;
    @(posedge clk);
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    busAddr = a;
    #1;
    d = busRdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cleanSlate();
    padIn = '0; periphOut = '0; periphOe = '0;
    wr(4'd7, 32'h0); wr(4'd6, 32'h0); wr(4'd0, 32'h0); wr(4'd1, 32'h0);
    wr(4'd8, 32'h0); wr(4'd9, 32'h0); wr(4'd12, 32'h0); wr(4'd13, 32'h0);
    idle(3);
    wr(4'd10, 32'hFFFF);
  endtask

  task automatic testReset();
    logic [31:0] v;
    @(negedge clk);
    check("R1", "padOe", {16'h0, padOe}, 32'h0);
    check("R1", "padOut", {16'h0, padOut}, 32'h0);
    check("R1", "irq", {31'h0, irq}, 32'h0);
    rd(4'd6, v);  check("R1", "input enable", v, 32'h0);
    rd(4'd7, v);  check("R1", "mask", v, 32'h0);
    rd(4'd11, v); check("R1", "input value", v, 32'h0);
    rd(4'd12, v); check("R1", "function select", v, 32'h0);
  endtask

  task automatic testDirData();
    logic [31:0] v;
    cleanSlate();
    wr(4'd0, 32'h00FF);
    wr(4'd1, 32'h1234);
    check("R2", "padOe", {16'h0, padOe}, 32'h00FF);
    check("R2", "padOut", {16'h0, padOut}, 32'h1234);
    rd(4'd1, v); check("R2", "data read", v, 32'h1234);
  endtask

  task automatic testAtomic();
    cleanSlate();
    wr(4'd1, 32'h1234);
    wr(4'd2, 32'h0F00);
    check("R3", "after set", {16'h0, padOut}, 32'h1F34);
    wr(4'd3, 32'h0030);
    check("R3", "after clear", {16'h0, padOut}, 32'h1F04);
    wr(4'd4, 32'hFFFF);
    check("R3", "after toggle", {16'h0, padOut}, 32'hE0FB);
  endtask

  task automatic testModify();
    cleanSlate();
    wr(4'd1, 32'h00F0);
    wr(4'd5, {16'h0030, 16'h0033});
    check("R4", "set and clear in one write", {16'h0, padOut}, 32'h00C3);
  endtask

  task automatic testInput();
    logic [31:0] v;
    cleanSlate();
    padIn = 16'hFFFF;
    wr(4'd6, 32'h000F);
    idle(2);
    rd(4'd11, v); check("R5", "gated input", v, 32'h000F);
    wr(4'd1, 32'h0002);
    wr(4'd0, 32'h0003);
    idle(2);
    rd(4'd11, v); check("R5", "loopback value", v, 32'h000E);
  endtask

  task automatic testFsel();
    logic [31:0] v;
    cleanSlate();
    periphOut[0] = 1'b1;  periphOe[0] = 1'b1;
    periphOut[17] = 1'b1; periphOe[17] = 1'b1;
    periphOut[50] = 1'b1; periphOe[50] = 1'b1;
    periphOut[3] = 1'b1;  periphOe[3] = 1'b1;
    periphOut[40] = 1'b1; periphOe[40] = 1'b1;
    wr(4'd12, 32'h0000_5421);
    check("R6", "padOut low pins", {28'h0, padOut[3:0]}, 32'h7);
    check("R6", "padOe low pins", {28'h0, padOe[3:0]}, 32'h7);
    rd(4'd12, v); check("R6", "select readback", v, 32'h0000_5421);
    check("R6", "pin8 before select", {31'h0, padOut[8]}, 32'h0);
    wr(4'd13, 32'h0000_0003);
    check("R6", "pin8 peripheral C", {31'h0, padOut[8]}, 32'h1);
  endtask

  task automatic testLevel();
    logic [31:0] v;
    cleanSlate();
    wr(4'd6, 32'h0010);
    wr(4'd7, 32'h0010);
    idle(2);
    check("R7", "irq idle", {31'h0, irq}, 32'h0);
    padIn[4] = 1'b1;
    idle(2);
    rd(4'd10, v); check("R7", "status high", v & 32'h10, 32'h10);
    check("R10", "irq level", {31'h0, irq}, 32'h1);
    wr(4'd10, 32'h0010);
    rd(4'd10, v); check("R12", "level status after clear", v & 32'h10, 32'h10);
    padIn[4] = 1'b0;
    idle(2);
    rd(4'd10, v); check("R7", "status low", v & 32'h10, 32'h0);
    check("R7", "irq low", {31'h0, irq}, 32'h0);
  endtask

  task automatic testRise();
    logic [31:0] v;
    cleanSlate();
    wr(4'd6, 32'h0020); wr(4'd8, 32'h0020); wr(4'd7, 32'h0020);
    idle(3);
    padIn[5] = 1'b1;
    idle(3);
    rd(4'd10, v); check("R8", "rising sets", v & 32'h20, 32'h20);
    padIn[5] = 1'b0;
    idle(3);
    rd(4'd10, v); check("R8", "sticky after fall", v & 32'h20, 32'h20);
    wr(4'd10, 32'h0020);
    idle(3);
    rd(4'd10, v); check("R8", "cleared", v & 32'h20, 32'h0);
    check("R8", "irq after clear", {31'h0, irq}, 32'h0);
    padIn[5] = 1'b1; idle(3);
    wr(4'd10, 32'h0020);
    padIn[5] = 1'b0; idle(3);
    rd(4'd10, v); check("R8", "fall ignored", v & 32'h20, 32'h0);
  endtask

  task automatic testBoth();
    logic [31:0] v;
    cleanSlate();
    wr(4'd6, 32'h0040); wr(4'd8, 32'h0040); wr(4'd9, 32'h0040);
    idle(3);
    padIn[6] = 1'b1; idle(3);
    rd(4'd10, v); check("R9", "rise", v & 32'h40, 32'h40);
    wr(4'd10, 32'h0040);
    idle(2);
    rd(4'd10, v); check("R9", "cleared", v & 32'h40, 32'h0);
    padIn[6] = 1'b0; idle(3);
    rd(4'd10, v); check("R9", "fall", v & 32'h40, 32'h40);
    check("R10", "irq masked off", {31'h0, irq}, 32'h0);
    wr(4'd7, 32'h0040);
    check("R10", "irq after mask open", {31'h0, irq}, 32'h1);
  endtask

  task automatic testLoopIrq();
    logic [31:0] v;
    cleanSlate();
    wr(4'd0, 32'h0080); wr(4'd6, 32'h0080);
    wr(4'd8, 32'h0080); wr(4'd7, 32'h0080);
    idle(3);
    check("R11", "irq before write", {31'h0, irq}, 32'h0);
    wr(4'd2, 32'h0080);
    idle(3);
    rd(4'd10, v); check("R11", "status via software", v & 32'h80, 32'h80);
    check("R11", "irq via software", {31'h0, irq}, 32'h1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    testReset();
    testDirData();
    testAtomic();
    testModify();
    testInput();
    testFsel();
    testLevel();
    testRise();
    testBoth();
    testLoopIrq();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule